// File: doc/BRIEF.md
# Module clock generator with phase taps

This block derives a peripheral module clock from one of several parent clock sources and also supplies two derived copies of it: an output clock and a sample clock. Each derived copy lags the module clock by a programmable whole number of parent-clock periods. One 32-bit configuration register controls all of it. The register holds a gate bit, a parent-select field, a power-of-two prescaler exponent P, a linear divider value M, and two 3-bit lag codes.

The block is fully synchronous to a single fabric clock `clk`. Each parent source arrives as a one-cycle tick on `src_tick`, and one tick marks one parent-clock period. A 2^P prescaler counts the ticks of the selected parent. Its wrap drives an (M+1) counter, so one module-clock period spans N = (M+1)·2^P parent periods. The module clock is high for the first floor(N/2) parent periods of each period. A single delay line, shifted once per parent period, records the module-clock level. Each derived clock is one tap of that line.

A three-state machine drives the module clock:
- ST_OFF is the gated state.
- ST_HI is the high part of a period.
- ST_LO is the low part of a period.

Its transitions are:
- ST_OFF to ST_HI: the enable bit is set. The period starts at position zero.
- ST_HI to ST_LO: the position within the period reaches floor(N/2).
- ST_LO to ST_HI: the period wraps.
- ST_HI to ST_HI: the period wraps while still high, which happens only when N = 1.
- ST_HI or ST_LO to ST_OFF: the enable bit is cleared.

On every period wrap, the divider and lag fields are copied into a working set, so a register write changes nothing until the next module-clock rising edge.

Top module: `modclk_phase_gen`

## Requirements
- R1: While bit 31 (enable) of the register is 0, `mod_clk`, `out_clk` and `smp_clk` are all 0, from the first cycle in which the register holds the cleared bit.
- R2: The register reads back on `rd_data` the cycle after a write. Only these bits are stored: 31 (enable), 24 and up (select, SEL_W wide), 22:20 (sample lag), 17:16 (P), 10:8 (output lag) and 3:0 (M). Every other bit reads 0, so writing all ones with SEL_W = 2 reads back 0x8373070F.
- R3: The select field picks `src_tick[sel]` as the parent. While the selected parent gives no tick, none of the three outputs changes.
- R4: The module-clock period is N = (M+1)·2^P parent-clock periods.
- R5: The module clock is high for floor(N/2) parent periods of each period and low for the rest. When N = 1 it stays high.
- R6: With a nonzero output-lag code D (bits 10:8), each rising edge of `out_clk` comes (D mod N) parent periods after a rising edge of `mod_clk`.
- R7: With a nonzero sample-lag code D (bits 22:20), each rising edge of `smp_clk` comes (D mod N) parent periods after a rising edge of `mod_clk`.
- R8: A lag code of 0 shifts the derived clock by half a period: floor(N/2) parent periods.
- R9: A change to M, P or a lag code written in mid-period leaves the current period whole. The new values apply from the next `mod_clk` rising edge.
- R10: After a write that sets the enable bit, `mod_clk` is 0 in the first cycle that holds the bit and 1 in the next, and a new period starts there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 2**SEL_W | One tick per period of each parent source |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register readback, reserved bits zero |
| mod_clk | output | 1 | Divided module clock |
| out_clk | output | 1 | Output clock, lagging by the output lag code |
| smp_clk | output | 1 | Sample clock, lagging by the sample lag code |

## Verification
Readback is due in the cycle after the write, and gating on a cleared enable bit is due in that same cycle. The first high level of the module clock comes one cycle later. The bench samples each of these at the falling edge of exactly those cycles. A new divider or lag setting applies only at a period wrap, and a stale delay line can hold up to 64 parent periods. So the scoreboard driver waits 300 cycles after each write before it queues expected period, high-time and lag values. The monitor then measures them in fabric cycles between two module-clock rising edges, scaled by the tick spacing of the selected source. The mid-period test measures the very period in which the write lands, and then the one after it.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

    localparam int REG_W   = 32;
    localparam int EN_BIT  = 31;
    localparam int SEL_LSB = 24;
    localparam int M_LSB   = 0;
    localparam int M_W     = 4;
    localparam int P_LSB   = 16;
    localparam int P_W     = 2;
    localparam int OPH_LSB = 8;
    localparam int SPH_LSB = 20;
    localparam int PH_W    = 3;

    // derived sizes
    localparam int P_MAX    = (1 << P_W) - 1;
    localparam int N_W      = M_W + P_MAX + 1;
    localparam int HALF_MAX = ((1 << M_W) << P_MAX) / 2;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_HI  = 2'd1,
        ST_LO  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic [PH_W-1:0] sph;
        logic [PH_W-1:0] oph;
        logic [P_W-1:0]  p;
        logic [M_W-1:0]  m;
    } div_cfg_t;

    function automatic logic [REG_W-1:0] cfg_mask(int sel_w);
        logic [REG_W-1:0] k;
        k = '0;
        k[EN_BIT] = 1'b1;
        for (int i = 0; i < sel_w; i++) k[SEL_LSB + i] = 1'b1;
        for (int i = 0; i < PH_W; i++) begin
            k[OPH_LSB + i] = 1'b1;
            k[SPH_LSB + i] = 1'b1;
        end
        for (int i = 0; i < P_W; i++) k[P_LSB + i] = 1'b1;
        for (int i = 0; i < M_W; i++) k[M_LSB + i] = 1'b1;
        return k;
    endfunction

endpackage

// File: rtl/mcg_cfg_reg.sv
module mcg_cfg_reg
    import mcg_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             en,
    output logic [SEL_W-1:0] sel,
    output div_cfg_t         fld
);

    localparam logic [REG_W-1:0] MASK = cfg_mask(SEL_W);

    logic [REG_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_data & MASK;
        end
    end

    assign rd_data = word_q;
    assign en      = word_q[EN_BIT];
    assign sel     = word_q[SEL_LSB +: SEL_W];
    assign fld.m   = word_q[M_LSB +: M_W];
    assign fld.p   = word_q[P_LSB +: P_W];
    assign fld.oph = word_q[OPH_LSB +: PH_W];
    assign fld.sph = word_q[SPH_LSB +: PH_W];

endmodule

// File: rtl/mcg_divider.sv
module mcg_divider
    import mcg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           tick,
    input  div_cfg_t       cfg_in,
    output div_cfg_t       act,
    output logic [N_W-1:0] half,
    output logic           mod_lvl,
    output logic           running
);

    div_state_e       state, nstate;
    logic [P_MAX-1:0] pcnt, pcnt_n;
    logic [M_W-1:0]   mcnt, mcnt_n;
    logic             load;
    logic [P_MAX-1:0] pre_top;
    logic             pre_wrap, per_wrap;
    logic [N_W-1:0]   n_act, pos_n;

    // working-set ratio and high time
    assign pre_top  = ~(P_MAX'({P_MAX{1'b1}} << act.p));
    assign pre_wrap = (pcnt == pre_top);
    assign per_wrap = pre_wrap && (mcnt == act.m);
    assign n_act    = N_W'({1'b0, act.m} + 1'b1) << act.p;
    assign half     = (n_act == N_W'(1)) ? N_W'(1) : (n_act >> 1);

    always_comb begin
        nstate = state;
        pcnt_n = pcnt;
        mcnt_n = mcnt;
        load   = 1'b0;
        pos_n  = '0;
        unique case (state)
            ST_OFF: begin
                pcnt_n = '0;
                mcnt_n = '0;
                load   = 1'b1;
                if (en) nstate = ST_HI;
            end
            ST_HI, ST_LO: begin
                if (!en) begin
                    nstate = ST_OFF;
                    pcnt_n = '0;
                    mcnt_n = '0;
                end else if (tick) begin
                    if (per_wrap) begin
                        pcnt_n = '0;
                        mcnt_n = '0;
                        load   = 1'b1;
                        nstate = ST_HI;
                    end else begin
                        if (pre_wrap) begin
                            pcnt_n = '0;
                            mcnt_n = mcnt + 1'b1;
                        end else begin
                            pcnt_n = pcnt + 1'b1;
                        end
                        pos_n  = (N_W'(mcnt_n) << act.p) | N_W'(pcnt_n);
                        nstate = (pos_n < half) ? ST_HI : ST_LO;
                    end
                end
            end
            default: begin
                nstate = ST_OFF;
            end
        endcase
    end

    // state register, counters and working set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            pcnt  <= '0;
            mcnt  <= '0;
            act   <= '0;
        end else begin
            state <= nstate;
            pcnt  <= pcnt_n;
            mcnt  <= mcnt_n;
            if (load) act <= cfg_in;
        end
    end

    // outputs
    always_comb begin
        mod_lvl = (state == ST_HI);
        running = (state != ST_OFF);
    end

endmodule

// File: rtl/mcg_phase_tap.sv
module mcg_phase_tap
    import mcg_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NTAP  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      adv,
    input  logic                      din,
    input  logic [NTAP-1:0][PH_W-1:0] code,
    input  logic [N_W-1:0]            half,
    output logic [NTAP-1:0]           tap
);

    localparam int IW = $clog2(DEPTH);

    logic [DEPTH-1:0] line_q;

    // one entry per parent period of module-clock history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (clr) begin
            line_q <= '0;
        end else if (adv) begin
            line_q <= {line_q[DEPTH-2:0], din};
        end
    end

    for (genvar g = 0; g < NTAP; g++) begin : g_tap
        logic [N_W-1:0] lag;
        logic [IW-1:0]  idx;
        assign lag    = (code[g] != '0) ? N_W'(code[g]) : half;
        assign idx    = IW'(lag - N_W'(1));
        assign tap[g] = line_q[idx];
    end

endmodule

// File: rtl/modclk_phase_gen.sv
module modclk_phase_gen
    import mcg_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<SEL_W)-1:0] src_tick,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    output logic [31:0]           rd_data,
    output logic                  mod_clk,
    output logic                  out_clk,
    output logic                  smp_clk
);

    localparam int LINE_D = (HALF_MAX > (1 << PH_W)) ? HALF_MAX : (1 << PH_W);

    logic                  en;
    logic [SEL_W-1:0]      sel;
    div_cfg_t              fld, act;
    logic                  tick;
    logic [N_W-1:0]        half;
    logic                  mod_lvl, running;
    logic [1:0][PH_W-1:0]  codes;
    logic [1:0]            taps;

    mcg_cfg_reg #(.SEL_W(SEL_W)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .en      (en),
        .sel     (sel),
        .fld     (fld)
    );

    assign tick = en & src_tick[sel];

    mcg_divider i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tick    (tick),
        .cfg_in  (fld),
        .act     (act),
        .half    (half),
        .mod_lvl (mod_lvl),
        .running (running)
    );

    assign codes[0] = act.oph;
    assign codes[1] = act.sph;

    mcg_phase_tap #(.DEPTH(LINE_D), .NTAP(2)) i_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!running),
        .adv   (tick & running),
        .din   (mod_lvl),
        .code  (codes),
        .half  (half),
        .tap   (taps)
    );

    assign mod_clk = en & mod_lvl;
    assign out_clk = en & taps[0];
    assign smp_clk = en & taps[1];

endmodule

// File: rtl/modclk_phase_gen_chk.sv
module modclk_phase_gen_chk
    import mcg_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [(1<<SEL_W)-1:0] src_tick,
    input logic [31:0]           rd_data,
    input logic                  mod_clk,
    input logic                  out_clk,
    input logic                  smp_clk
);

    localparam logic [31:0] MASK = cfg_mask(SEL_W);

    logic en_v, tick_v;
    assign en_v   = rd_data[EN_BIT];
    assign tick_v = src_tick[rd_data[SEL_LSB +: SEL_W]];

    // R1
    gated_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_v |-> (!mod_clk && !out_clk && !smp_clk));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~MASK) == 32'h0);

    // R3
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_v && $past(en_v) && $past(en_v, 2) && !$past(tick_v))
        |-> ($stable(mod_clk) && $stable(out_clk) && $stable(smp_clk)));

    // R10
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_v) |-> !mod_clk);

    // R10
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_v) |=> (mod_clk || !en_v));

endmodule

bind modclk_phase_gen modclk_phase_gen_chk #(.SEL_W(SEL_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .rd_data  (rd_data),
    .mod_clk  (mod_clk),
    .out_clk  (out_clk),
    .smp_clk  (smp_clk)
);

// File: tb/test_modclk_phase_gen.sv
module test_modclk_phase_gen;

    localparam int SEL_W = 2;
    localparam int NSRC  = 1 << SEL_W;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NSRC-1:0] src_tick;
    logic            wr_en;
    logic [31:0]     wr_data;
    logic [31:0]     rd_data;
    logic            mod_clk, out_clk, smp_clk;

    int n_run  = 0;
    int n_fail = 0;
    int ph     = 0;

    typedef struct {
        int per;
        int hi;
        int lag_o;
        int lag_s;
        bit half_o;
        bit half_s;
    } exp_t;

    exp_t sb_q[$];
    bit   mon_busy = 1'b0;

    always #5 clk = ~clk;

    modclk_phase_gen #(.SEL_W(SEL_W)) i_modclk_phase_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .mod_clk  (mod_clk),
        .out_clk  (out_clk),
        .smp_clk  (smp_clk)
    );

    // parent sources: 0 every cycle, 1 every third, 2 never, 3 every second
    initial begin
        src_tick = '0;
        forever begin
            @(negedge clk);
            ph = ph + 1;
            src_tick[0] = 1'b1;
            src_tick[1] = (ph % 3 == 0);
            src_tick[2] = 1'b0;
            src_tick[3] = (ph % 2 == 0);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    function automatic logic [31:0] mk(input bit en, input int sel, input int m, input int p,
                                       input int od, input int sd);
        return (32'(en) << 31) | (32'(sel) << 24) | (32'(sd) << 20) | (32'(p) << 16)
             | (32'(od) << 8) | 32'(m);
    endfunction

    // drive at a falling edge; returns at the falling edge after capture
    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_rise();
        logic pm;
        pm = mod_clk;
        @(negedge clk);
        while (!(mod_clk && !pm)) begin
            pm = mod_clk;
            @(negedge clk);
        end
    endtask

    task automatic period_from_rise(output int per, output int hi);
        logic pm;
        int k;
        k  = 0;
        hi = 0;
        forever begin
            if (mod_clk) hi++;
            pm = mod_clk;
            @(negedge clk);
            wr_en = 1'b0;
            k++;
            if (mod_clk && !pm) break;
        end
        per = k;
    endtask

    // scoreboard driver
    task automatic expect_wave(input int sel, input int m, input int p, input int od, input int sd);
        exp_t e;
        int n, h, sc;
        write_cfg(mk(1'b1, sel, m, p, od, sd));
        repeat (300) @(negedge clk);
        n  = (m + 1) << p;
        h  = (n == 1) ? 1 : n / 2;
        sc = (sel == 1) ? 3 : ((sel == 3) ? 2 : 1);
        e.per    = n * sc;
        e.hi     = h * sc;
        e.lag_o  = ((od != 0) ? (od % n) : (h % n)) * sc;
        e.lag_s  = ((sd != 0) ? (sd % n) : (h % n)) * sc;
        e.half_o = (od == 0);
        e.half_s = (sd == 0);
        sb_q.push_back(e);
        while (sb_q.size() > 0 || mon_busy) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        logic pm, po, ps;
        int k, hi, lo, ls;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                mon_busy = 1'b1;
                e = sb_q.pop_front();
                pm = mod_clk; po = out_clk; ps = smp_clk;
                @(negedge clk);
                while (!(mod_clk && !pm)) begin
                    pm = mod_clk; po = out_clk; ps = smp_clk;
                    @(negedge clk);
                end
                k = 0; hi = 0; lo = -1; ls = -1;
                forever begin
                    if (lo < 0 && out_clk && !po) lo = k;
                    if (ls < 0 && smp_clk && !ps) ls = k;
                    if (mod_clk) hi++;
                    pm = mod_clk; po = out_clk; ps = smp_clk;
                    @(negedge clk);
                    k++;
                    if (mod_clk && !pm) break;
                end
                check("R4", "period cycles", k, e.per);
                check("R5", "high cycles", hi, e.hi);
                check(e.half_o ? "R8" : "R6", "out_clk lag", lo, e.lag_o);
                check(e.half_s ? "R8" : "R7", "smp_clk lag", ls, e.lag_s);
                mon_busy = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int per, hi, cnt;
        logic [2:0] s0;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (5) @(negedge clk);
        // reset state
        check("R2", "reset readback", int'(rd_data), 0);
        check("R1", "reset outputs", int'({mod_clk, out_clk, smp_clk}), 0);
        rst_n = 1'b1;

        // R2 readback mask
        write_cfg(32'hFFFF_FFFF);
        check("R2", "all-ones readback", int'(rd_data), int'(32'h8373_070F));
        write_cfg(32'h0);
        check("R2", "zero readback", int'(rd_data), 0);
        check("R1", "outputs after clear", int'({mod_clk, out_clk, smp_clk}), 0);

        // R10 enable start
        write_cfg(mk(1'b1, 0, 3, 0, 1, 0));
        check("R10", "mod_clk first cycle", int'(mod_clk), 0);
        @(negedge clk);
        check("R10", "mod_clk second cycle", int'(mod_clk), 1);

        // R4..R8 rate and phase under several settings
        expect_wave(0, 3, 0, 1, 0);
        expect_wave(0, 2, 0, 2, 4);
        expect_wave(0, 1, 2, 7, 3);
        expect_wave(0, 15, 3, 0, 6);
        expect_wave(3, 4, 1, 3, 0);
        expect_wave(0, 0, 1, 3, 2);
        expect_wave(1, 1, 1, 2, 0);

        // R5 ratio of one keeps the module clock high
        write_cfg(mk(1'b1, 0, 0, 0, 1, 1));
        repeat (300) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (!mod_clk) cnt++;
            @(negedge clk);
        end
        check("R5", "low samples at ratio 1", cnt, 0);

        // R9 mid-period write
        write_cfg(mk(1'b1, 0, 7, 0, 1, 1));
        repeat (300) @(negedge clk);
        wait_rise();
        wr_en   = 1'b1;
        wr_data = mk(1'b1, 0, 1, 0, 1, 1);
        period_from_rise(per, hi);
        check("R9", "period in progress", per, 8);
        check("R9", "high time in progress", hi, 4);
        period_from_rise(per, hi);
        check("R9", "next period", per, 2);
        check("R9", "next high time", hi, 1);

        // R3 parent without ticks freezes outputs
        write_cfg(mk(1'b1, 0, 3, 0, 1, 2));
        repeat (50) @(negedge clk);
        write_cfg(mk(1'b1, 2, 3, 0, 1, 2));
        s0  = {mod_clk, out_clk, smp_clk};
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if ({mod_clk, out_clk, smp_clk} != s0) cnt++;
        end
        check("R3", "changes without ticks", cnt, 0);

        // R1 disable holds all low
        write_cfg(mk(1'b1, 0, 3, 0, 1, 2));
        repeat (50) @(negedge clk);
        write_cfg(mk(1'b0, 0, 3, 0, 1, 2));
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (mod_clk || out_clk || smp_clk) cnt++;
            @(negedge clk);
        end
        check("R1", "high samples while disabled", cnt, 0);

        report();
        $finish;
    end

endmodule